// File: doc/BRIEF.md
# Accumulator ALU with Registered Flags

This block is the arithmetic and logic datapath of a small single-cycle processor core. Each cycle in which `en` is high it takes an operation code, two byte operands and a 3-bit shift amount or bit index. It produces a combinational result for the destination register. It also updates its own accumulator register and its carry (C), overflow (V) and zero (Z) flags at the clock edge. The current flags feed back into the operations that need them: carry-in, borrow, and conditional moves. Decode and the general register file sit outside the block. `op1` is the first source and the value of the destination. `op2` is the second source, or the value kept by a conditional move.

Carry follows the inverted-borrow rule: after a subtraction, C=1 means no borrow happened. Multiplies and multi-byte shifts split a 16-bit value between the result and the accumulator. Flag save and flag load pack the flags into a byte so that software can keep them and put them back.

Top module: `alu8_acc`

## Requirements
- R1: `rst_n` is an active-low reset, sampled on the clock edge. While it is low, the accumulator and the C, V and Z flags all clear to 0, whatever `en` is.
- R2: While `en` is 0, the accumulator and flags hold. Opcode 0 (no-op) and the unused codes 26 to 31 leave them unchanged even with `en` high. For these codes, and for codes 18, 19, 20, 24 and 25, `result` equals `op1`.
- R3: Opcode 7 (add) and opcode 8 (add with carry) form `op1+op2`, and opcode 8 adds C as well. C is the carry out and V is the signed overflow. Z is set when the result is zero, and the accumulator takes the result.
- R4: Opcode 9 computes `op1-op2`, and opcode 10 computes `op1-op2-(1-C)`. C is 1 when no borrow occurs and 0 on underflow. V is the signed overflow, Z is set on a zero result, and the accumulator takes the result.
- R5: Opcodes 11 and 12 compute `op2-op1` and `op2-op1-(1-C)`, with the same flag and accumulator rules as R4.
- R6: Opcode 13 multiplies unsigned and opcode 14 multiplies two's-complement signed. The upper byte of the 16-bit product is `result` and the lower byte goes to the accumulator. The flags do not change.
- R7: Opcode 15 shifts `op1` left by `idx`. The result is the low byte, and the bits pushed out go to the low end of the accumulator. Opcode 16 shifts right with zero fill, and the bits pushed out go to the high end of the accumulator. Opcode 17 is the same as 16 but fills with the sign bit. The flags do not change.
- R8: Opcode 18 (unsigned) and opcode 19 (signed) compare the operands. C=0 when `op2 > op1`, otherwise C=1. Z=1 when the operands are equal, and V = C AND NOT Z. The accumulator does not change.
- R9: Opcode 20 sets Z to the inverse of `op1[idx]`. Opcodes 21, 22 and 23 set, clear or invert only bit `idx` of `op1` to form the result, and Z reflects that result. All four copy the result to the accumulator and keep C and V.
- R10: Opcode 1 (move) passes `op1`. Opcodes 4, 5 and 6 give AND, OR and XOR of the operands. Each sets Z from the result, copies the result to the accumulator and keeps C and V.
- R11: Opcode 2 gives `op1` when C=0 and `op2` otherwise. Opcode 3 gives `op1` when C=1 and `op2` otherwise. Z and the accumulator follow the result.
- R12: Opcode 24 loads the accumulator with C in bit 7, C XOR V in bit 6 and zeros in bits 5 to 0. The flags do not change.
- R13: Opcode 25 loads C from `op1[7]`, V from `op1[7]` XOR `op1[6]` and Z from `op1[5]`. The accumulator does not change, so saving with R12 and then loading the saved byte restores C and V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Execute strobe; state updates only when high |
| opcode | input | 5 | Operation code |
| op1 | input | 8 | First operand and destination value |
| op2 | input | 8 | Second operand |
| idx | input | 3 | Shift amount or bit index |
| result | output | 8 | Combinational value for the destination |
| acc | output | 8 | Accumulator register |
| c_flag | output | 1 | Carry flag (inverted borrow) |
| v_flag | output | 1 | Overflow flag |
| z_flag | output | 1 | Zero flag |

## Verification
Before each operation, the flags are preloaded to a chosen pattern with a flag load. This tells apart operations that read C (carry-in, borrow, conditional moves) from those that ignore it, and shows which flags each operation leaves alone. The operand pairs are chosen so that each one separates a pair of behaviours:
- 0x80 times 0x02 gives a different upper byte for signed and unsigned multiply.
- 0x80 against 0x10 orders differently in signed and unsigned compare.
- 0x70+0x20 and 0x80-0x01 raise V without C and with C.
- 0xB3 shifted by 3 separates zero fill from sign fill and shows where the spilled bits land.

Directed cases cover reset, a held strobe, unused codes and a save-then-load of the flags.

// File: rtl/alu8_pkg.sv
// Shared types of the accumulator ALU: operation codes and the flag bundle.
// Assumes that decode outside the block maps instructions onto these codes.
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_NOP   = 5'd0,
        OP_MOVE  = 5'd1,
        OP_CMVZ  = 5'd2,
        OP_CMVO  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_ADD   = 5'd7,
        OP_ADDC  = 5'd8,
        OP_SUB   = 5'd9,
        OP_SUBB  = 5'd10,
        OP_RSUB  = 5'd11,
        OP_RSUBB = 5'd12,
        OP_MULU  = 5'd13,
        OP_MULS  = 5'd14,
        OP_SHL   = 5'd15,
        OP_SHR   = 5'd16,
        OP_SHRA  = 5'd17,
        OP_CMPU  = 5'd18,
        OP_CMPS  = 5'd19,
        OP_BTST  = 5'd20,
        OP_BSET  = 5'd21,
        OP_BCLR  = 5'd22,
        OP_BINV  = 5'd23,
        OP_FSAVE = 5'd24,
        OP_FLOAD = 5'd25
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic v;
        logic z;
    } alu_flags_t;

endpackage

// File: rtl/alu8_addsub.sv
// Adder/subtractor and comparator of the ALU.
// Handles add, add with carry, direct and swapped subtraction (with and without
// borrow) and both compares. Carry out on subtraction is an inverted borrow.
// Assumes op is one of those codes whenever its outputs are selected.
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           c_o,
    output logic           v_o,
    output logic           z_o
);

    localparam int M = W - 1;

    logic [W:0]   sum;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         brw;
    logic         is_sub;
    logic         is_swap;
    logic         use_c;

    // Classify the operation into add or subtract, operand order and carry use.
    always_comb begin
        is_sub  = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_RSUB) || (op == OP_RSUBB);
        is_swap = (op == OP_RSUB) || (op == OP_RSUBB);
        use_c   = (op == OP_ADDC) || (op == OP_SUBB) || (op == OP_RSUBB);
    end

    // Form the sum or difference and derive the flags.
    always_comb begin
        x   = is_swap ? b : a;
        y   = is_swap ? a : b;
        brw = use_c & ~cin;
        if (is_sub) begin
            sum = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, brw};
            c_o = ~sum[W];
            v_o = (x[M] != y[M]) && (sum[M] != x[M]);
        end else begin
            sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, use_c & cin};
            c_o = sum[W];
            v_o = (a[M] == b[M]) && (sum[M] != a[M]);
        end
        res = sum[W-1:0];
        z_o = (sum[W-1:0] == '0);
        if (op == OP_CMPU || op == OP_CMPS) begin
            res = a;
            z_o = (a == b);
            if (op == OP_CMPS) begin
                c_o = !($signed(b) > $signed(a));
            end else begin
                c_o = !(b > a);
            end
            v_o = c_o & ~z_o;
        end
    end

endmodule

// File: rtl/alu8_mulshift.sv
// Multiplier and two-word shifter of the ALU.
// Produces a double-width value whose one half goes to the destination and the
// other half to the accumulator. Assumes sh is below W.
module alu8_mulshift
    import alu8_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [IW-1:0]  sh,
    output logic [W-1:0]   res,
    output logic [W-1:0]   acc_o
);

    localparam int M  = W - 1;
    localparam int W2 = 2 * W;

    logic [W2-1:0]        prod_u;
    logic [W2-1:0]        prod_s;
    logic [W2-1:0]        w_shl;
    logic [W2-1:0]        w_shr;
    logic signed [W2-1:0] w_sra;

    // Unsigned and sign-extended products, both truncated to double width.
    always_comb begin
        prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        prod_s = {{W{a[M]}}, a} * {{W{b[M]}}, b};
    end

    // Shift the operand into a double-width window in each direction.
    always_comb begin
        w_shl = {{W{1'b0}}, a} << sh;
        w_shr = {a, {W{1'b0}}} >> sh;
        w_sra = $signed({a, {W{1'b0}}}) >>> sh;
    end

    // Pick the halves for destination and accumulator.
    always_comb begin
        unique case (op)
            OP_MULS: begin res = prod_s[W2-1:W]; acc_o = prod_s[W-1:0]; end
            OP_SHL:  begin res = w_shl[W-1:0];   acc_o = w_shl[W2-1:W]; end
            OP_SHR:  begin res = w_shr[W2-1:W];  acc_o = w_shr[W-1:0];  end
            OP_SHRA: begin res = w_sra[W2-1:W];  acc_o = w_sra[W-1:0];  end
            default: begin res = prod_u[W2-1:W]; acc_o = prod_u[W-1:0]; end
        endcase
    end

endmodule

// File: rtl/alu8_bitlogic.sv
// Logic, move, conditional move and single-bit operations of the ALU.
// The bit mask is decoded one-hot from idx. Assumes that the caller selects the
// outputs only for those codes.
module alu8_bitlogic
    import alu8_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [IW-1:0]  idx,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           z_o
);

    logic [W-1:0] mask;
    logic         bit_sel;

    // One-hot bit mask, one decoder per bit position.
    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (idx == IW'(g));
    end

    assign bit_sel = |(a & mask);

    // Compute the result and the zero flag for each operation.
    always_comb begin
        unique case (op)
            OP_CMVZ: res = cin ? b : a;
            OP_CMVO: res = cin ? a : b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_BSET: res = a | mask;
            OP_BCLR: res = a & ~mask;
            OP_BINV: res = a ^ mask;
            default: res = a;
        endcase
        z_o = (op == OP_BTST) ? ~bit_sel : (res == '0);
    end

endmodule

// File: rtl/alu8_acc.sv
// Top of the accumulator ALU. Routes operands to the three function units,
// chooses the result, and registers the accumulator and the C/V/Z flags when
// en is high. Reset is synchronous and active low. Assumes W >= 3, because the
// flag byte uses the top three bits.
module alu8_acc
    import alu8_pkg::*;
#(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [4:0]     opcode,
    input  logic [W-1:0]   op1,
    input  logic [W-1:0]   op2,
    input  logic [IW-1:0]  idx,
    output logic [W-1:0]   result,
    output logic [W-1:0]   acc,
    output logic           c_flag,
    output logic           v_flag,
    output logic           z_flag
);

    alu_op_e    op;
    alu_flags_t fl_q, fl_n;
    logic [W-1:0] acc_q, acc_n;

    logic [W-1:0] as_res, ms_res, ms_acc, bl_res;
    logic         as_c, as_v, as_z, bl_z;

    assign op = alu_op_e'(opcode);

    alu8_addsub #(.W(W)) u_addsub (
        .op (op), .a (op1), .b (op2), .cin (fl_q.c),
        .res (as_res), .c_o (as_c), .v_o (as_v), .z_o (as_z)
    );

    alu8_mulshift #(.W(W)) u_mulshift (
        .op (op), .a (op1), .b (op2), .sh (idx),
        .res (ms_res), .acc_o (ms_acc)
    );

    alu8_bitlogic #(.W(W)) u_bitlogic (
        .op (op), .a (op1), .b (op2), .idx (idx), .cin (fl_q.c),
        .res (bl_res), .z_o (bl_z)
    );

    // Select the result and form the next accumulator and flags.
    always_comb begin
        result = op1;
        acc_n  = acc_q;
        fl_n   = fl_q;
        case (op)
            OP_MOVE, OP_CMVZ, OP_CMVO, OP_AND, OP_OR, OP_XOR,
            OP_BTST, OP_BSET, OP_BCLR, OP_BINV: begin
                result = bl_res;
                acc_n  = bl_res;
                fl_n.z = bl_z;
            end
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUB, OP_RSUBB: begin
                result = as_res;
                acc_n  = as_res;
                fl_n   = '{c: as_c, v: as_v, z: as_z};
            end
            OP_CMPU, OP_CMPS: begin
                fl_n = '{c: as_c, v: as_v, z: as_z};
            end
            OP_MULU, OP_MULS, OP_SHL, OP_SHR, OP_SHRA: begin
                result = ms_res;
                acc_n  = ms_acc;
            end
            OP_FSAVE: begin
                acc_n = {fl_q.c, fl_q.c ^ fl_q.v, {(W-2){1'b0}}};
            end
            OP_FLOAD: begin
                fl_n = '{c: op1[W-1], v: op1[W-1] ^ op1[W-2], z: op1[W-3]};
            end
            default: ;
        endcase
    end

    // Accumulator and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            fl_q  <= '0;
        end else if (en) begin
            acc_q <= acc_n;
            fl_q  <= fl_n;
        end
    end

    assign acc    = acc_q;
    assign c_flag = fl_q.c;
    assign v_flag = fl_q.v;
    assign z_flag = fl_q.z;

endmodule

// File: rtl/alu8_acc_chk.sv
// Property checker for the accumulator ALU, bound to every instance of the top.
// It watches the ports only.
module alu8_acc_chk #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic [4:0]     opcode,
    input logic [W-1:0]   op1,
    input logic [W-1:0]   op2,
    input logic [IW-1:0]  idx,
    input logic [W-1:0]   result,
    input logic [W-1:0]   acc,
    input logic           c_flag,
    input logic           v_flag,
    input logic           z_flag
);

    logic [W:0]   add_w;
    logic [W-1:0] prod_lo;
    logic         sel_bit;

    assign add_w   = {1'b0, op1} + {1'b0, op2};
    assign prod_lo = op1 * op2;
    assign sel_bit = op1[idx];

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (acc == '0) && !c_flag && !v_flag && !z_flag);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc) && $stable(c_flag) && $stable(v_flag) && $stable(z_flag));

    a_r3_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        en && opcode == 5'd7 |=> {c_flag, acc} == $past(add_w));

    a_r6_mul_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        en && opcode == 5'd13 |=> acc == $past(prod_lo));

    a_r8_cmp_v_not_z: assert property (@(posedge clk) disable iff (!rst_n)
        en && (opcode == 5'd18 || opcode == 5'd19) |=> !(v_flag && z_flag));

    a_r9_btst_zero: assert property (@(posedge clk) disable iff (!rst_n)
        en && opcode == 5'd20 |=> z_flag == !$past(sel_bit));

    a_r10_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        en && (opcode == 5'd4 || opcode == 5'd5 || opcode == 5'd6)
        |=> c_flag == $past(c_flag) && v_flag == $past(v_flag));

    a_r12_flag_save: assert property (@(posedge clk) disable iff (!rst_n)
        en && opcode == 5'd24
        |=> acc[W-1] == $past(c_flag) && acc[W-2] == $past(c_flag ^ v_flag));

endmodule

bind alu8_acc alu8_acc_chk #(.W(W)) u_alu8_acc_chk (
    .clk (clk), .rst_n (rst_n), .en (en), .opcode (opcode),
    .op1 (op1), .op2 (op2), .idx (idx), .result (result), .acc (acc),
    .c_flag (c_flag), .v_flag (v_flag), .z_flag (z_flag)
);

// File: tb/test_alu8_acc.sv
// Bench for alu8_acc: a vector table preceded by MOVE 0xA5 and a flag load,
// then directed reset, hold, unused-code and flag round-trip cases.
module test_alu8_acc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [4:0] opcode = '0;
    logic [7:0] op1 = '0, op2 = '0;
    logic [2:0] idx = '0;
    logic [7:0] result, acc;
    logic       c_flag, v_flag, z_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu8_acc i_alu8_acc (
        .clk (clk), .rst_n (rst_n), .en (en), .opcode (opcode),
        .op1 (op1), .op2 (op2), .idx (idx), .result (result), .acc (acc),
        .c_flag (c_flag), .v_flag (v_flag), .z_flag (z_flag)
    );

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [2:0] i;
        logic [2:0] pre;   // c, v, z before
        logic [7:0] res;
        logic [7:0] acc;
        logic [2:0] fl;    // c, v, z after
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{5'd7,  8'h70, 8'h20, 3'd0, 3'b000, 8'h90, 8'h90, 3'b010}, // R3 signed overflow
        '{5'd7,  8'hFF, 8'h01, 3'd0, 3'b000, 8'h00, 8'h00, 3'b101}, // R3 carry, zero
        '{5'd8,  8'h10, 8'h20, 3'd0, 3'b100, 8'h31, 8'h31, 3'b000}, // R3 carry in
        '{5'd9,  8'h05, 8'h07, 3'd0, 3'b111, 8'hFE, 8'hFE, 3'b000}, // R4 underflow
        '{5'd9,  8'h80, 8'h01, 3'd0, 3'b000, 8'h7F, 8'h7F, 3'b110}, // R4 overflow
        '{5'd10, 8'h07, 8'h05, 3'd0, 3'b000, 8'h01, 8'h01, 3'b100}, // R4 borrow term
        '{5'd11, 8'h05, 8'h07, 3'd0, 3'b000, 8'h02, 8'h02, 3'b100}, // R5
        '{5'd12, 8'h01, 8'h80, 3'd0, 3'b100, 8'h7F, 8'h7F, 3'b110}, // R5 no borrow
        '{5'd12, 8'h05, 8'h07, 3'd0, 3'b000, 8'h01, 8'h01, 3'b100}, // R5 borrow term
        '{5'd13, 8'hFF, 8'hFF, 3'd0, 3'b101, 8'hFE, 8'h01, 3'b101}, // R6 unsigned
        '{5'd14, 8'hFF, 8'h02, 3'd0, 3'b000, 8'hFF, 8'hFE, 3'b000}, // R6 signed
        '{5'd14, 8'h80, 8'h02, 3'd0, 3'b011, 8'hFF, 8'h00, 3'b011}, // R6 signed
        '{5'd15, 8'hB3, 8'h00, 3'd3, 3'b010, 8'h98, 8'h05, 3'b010}, // R7 left
        '{5'd15, 8'hB3, 8'h00, 3'd0, 3'b000, 8'hB3, 8'h00, 3'b000}, // R7 zero shift
        '{5'd16, 8'hB3, 8'h00, 3'd3, 3'b000, 8'h16, 8'h60, 3'b000}, // R7 right
        '{5'd17, 8'hB3, 8'h00, 3'd3, 3'b000, 8'hF6, 8'h60, 3'b000}, // R7 arith
        '{5'd18, 8'h80, 8'h10, 3'd0, 3'b000, 8'h80, 8'hA5, 3'b110}, // R8 unsigned
        '{5'd19, 8'h80, 8'h10, 3'd0, 3'b111, 8'h80, 8'hA5, 3'b000}, // R8 signed
        '{5'd18, 8'h33, 8'h33, 3'd0, 3'b000, 8'h33, 8'hA5, 3'b101}, // R8 equal
        '{5'd20, 8'h04, 8'h00, 3'd2, 3'b110, 8'h04, 8'h04, 3'b110}, // R9 test set bit
        '{5'd20, 8'h04, 8'h00, 3'd3, 3'b000, 8'h04, 8'h04, 3'b001}, // R9 test clear bit
        '{5'd21, 8'h00, 8'h00, 3'd7, 3'b001, 8'h80, 8'h80, 3'b000}, // R9 set
        '{5'd22, 8'h08, 8'h00, 3'd3, 3'b110, 8'h00, 8'h00, 3'b111}, // R9 clear
        '{5'd23, 8'h0F, 8'h00, 3'd0, 3'b000, 8'h0E, 8'h0E, 3'b000}, // R9 invert
        '{5'd4,  8'hF0, 8'h3C, 3'd0, 3'b111, 8'h30, 8'h30, 3'b110}, // R10 and
        '{5'd6,  8'h5A, 8'h5A, 3'd0, 3'b000, 8'h00, 8'h00, 3'b001}, // R10 xor
        '{5'd5,  8'h41, 8'h02, 3'd0, 3'b010, 8'h43, 8'h43, 3'b010}, // R10 or
        '{5'd2,  8'h11, 8'h22, 3'd0, 3'b000, 8'h11, 8'h11, 3'b000}, // R11 C=0 taken
        '{5'd2,  8'h11, 8'h22, 3'd0, 3'b100, 8'h22, 8'h22, 3'b100}, // R11 C=1 kept
        '{5'd3,  8'h11, 8'h22, 3'd0, 3'b100, 8'h11, 8'h11, 3'b100}, // R11 C=1 taken
        '{5'd3,  8'h11, 8'h22, 3'd0, 3'b000, 8'h22, 8'h22, 3'b000}, // R11 C=0 kept
        '{5'd24, 8'h3C, 8'h00, 3'd0, 3'b100, 8'h3C, 8'hC0, 3'b100}, // R12
        '{5'd24, 8'h3C, 8'h00, 3'd0, 3'b010, 8'h3C, 8'h40, 3'b010}, // R12
        '{5'd1,  8'h00, 8'h00, 3'd0, 3'b110, 8'h00, 8'h00, 3'b111}, // R10 move zero
        '{5'd0,  8'h77, 8'h00, 3'd0, 3'b010, 8'h77, 8'hA5, 3'b010}  // R2 no-op
    };

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'd7, 5'd8:               return "R3";
            5'd9, 5'd10:              return "R4";
            5'd11, 5'd12:             return "R5";
            5'd13, 5'd14:             return "R6";
            5'd15, 5'd16, 5'd17:      return "R7";
            5'd18, 5'd19:             return "R8";
            5'd20, 5'd21, 5'd22, 5'd23: return "R9";
            5'd1, 5'd4, 5'd5, 5'd6:   return "R10";
            5'd2, 5'd3:               return "R11";
            5'd24:                    return "R12";
            5'd25:                    return "R13";
            default:                  return "R2";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] i, input logic e);
        opcode = o; op1 = a; op2 = b; idx = i; en = e;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Load flags c,v,z through the flag-load code (R13 encoding).
    task automatic load_flags(input logic [2:0] f);
        drive(5'd25, {f[2], f[2] ^ f[1], f[0], 5'b0}, 8'h00, 3'd0, 1'b1);
        tick();
    endtask

    function automatic logic [7:0] st();
        return {5'b0, c_flag, v_flag, z_flag};
    endfunction

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R1: reset state
        check("R1", "acc after reset", acc, 8'h00);
        check("R1", "flags after reset", st(), 8'h00);
        rst_n = 1'b1;

        for (int n = 0; n < NV; n++) begin
            drive(5'd1, 8'hA5, 8'h00, 3'd0, 1'b1);
            tick();
            load_flags(VECS[n].pre);
            drive(VECS[n].op, VECS[n].a, VECS[n].b, VECS[n].i, 1'b1);
            #1;
            check(req_of(VECS[n].op), "result", result, VECS[n].res);
            tick();
            check(req_of(VECS[n].op), "acc", acc, VECS[n].acc);
            check(req_of(VECS[n].op), "flags", st(), {5'b0, VECS[n].fl});
        end

        // R2: strobe low holds state
        load_flags(3'b000);
        drive(5'd1, 8'h5A, 8'h00, 3'd0, 1'b1);
        tick();
        drive(5'd7, 8'hFF, 8'h01, 3'd0, 1'b0);
        tick();
        check("R2", "acc held", acc, 8'h5A);
        check("R2", "flags held", st(), 8'h00);

        // R2: unused code has no effect and passes op1
        drive(5'd30, 8'h3E, 8'hFF, 3'd5, 1'b1);
        #1;
        check("R2", "unused result", result, 8'h3E);
        tick();
        check("R2", "unused acc", acc, 8'h5A);
        check("R2", "unused flags", st(), 8'h00);

        // R12 then R13: save c=0,v=1 and load it back
        load_flags(3'b010);
        drive(5'd24, 8'h00, 8'h00, 3'd0, 1'b1);
        tick();
        check("R12", "saved byte", acc, 8'h40);
        load_flags(3'b111);
        drive(5'd25, acc, 8'h00, 3'd0, 1'b1);
        #1;
        check("R13", "load result", result, 8'h40);
        tick();
        check("R13", "restored flags", st(), 8'h02);
        check("R13", "acc unchanged", acc, 8'h40);

        // R1: reset wins over a strobed operation
        drive(5'd7, 8'hFF, 8'h01, 3'd0, 1'b1);
        rst_n = 1'b0;
        tick();
        check("R1", "acc in reset", acc, 8'h00);
        check("R1", "flags in reset", st(), 8'h00);
        rst_n = 1'b1;
        en = 1'b0;
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule